// File: doc/BRIEF.md
# Isolated Driver Operating-State Sequencer

This block is the central control state machine of a two-sided isolated gate driver. It tracks whether the input and output supplies are good, the PWM input level, the shared ready and fault lines, and writes to a small set of control registers. From these it walks the driver through seven operating states: powered off, address setup, parameter setup, parameter transfer, normal run, not-ready and fault. The current state decides which register classes a bus master may write, whether PWM is passed to the power stage, and whether the ready line is pulled low.

Parameter transfer across the isolation barrier is a handshake. The sequencer raises a transfer request and waits for the output side's ready acknowledge. Fault-clear timing lives in a separate block, which reports completion on a single done input. After one side loses power, the sequencer either soft-resets the configuration or, when the matching arm bit is set, re-transfers the stored configuration. A restore re-sends the configuration to the output side. A recover reloads it from the output side. Each success sets a sticky flag.

Top module: `drv_opstate_seq`

## Requirements
- R1: While reset is active the state reads OFF (state code 0), the ready pull-down is on, PWM enable and all four write permissions are low, and the lock, user-OK, arm and done flags are all 0. State codes are OFF=0, ADDR=1, PARAM=2, XFER=3, NORMAL=4, NOTRDY=5, FAULT=6.
- R2: OFF is left for ADDR only when the input supply is good and the PWM input is high. This ordinary exit clears the lock and user-OK flags, clears both arm bits and pulses the defaults strobe for one cycle.
- R3: In ADDR, an accepted write of 1 to bit 0 of the lock register (address 0x02) sets the lock and moves to PARAM, while a write of 0 leaves the state in ADDR. In PARAM, writing 0 to that bit clears the lock and returns to ADDR.
- R4: Write permissions follow the state. ADDR permits the device and group address registers (0x00, 0x01) and the lock register. PARAM permits the lock, user-OK and configuration registers (0x03 to 0x25). NOTRDY permits only the user-OK register (0x1C). Every other state permits nothing.
- R5: In PARAM, writing 1 to bit 0 of the user-OK register moves to XFER. XFER moves to NORMAL only in a cycle where both the output supply is good and the secondary-ready acknowledge is high.
- R6: NORMAL moves to NOTRDY when the ready line is low and returns when the line is high. In NOTRDY, writing 0 to user-OK clears it and moves to PARAM, and this takes priority over the ready line.
- R7: NORMAL moves to FAULT when the fault line is low or the output side reports a fault, and this takes priority over a low ready line. FAULT returns to NORMAL when the fault-clear done input is high.
- R8: A write the current state does not permit is not acknowledged (regAccept low), and it changes neither the state nor any flag.
- R9: In PARAM, writing bit 0 of the safety register (0x1D) performs a soft reset: the defaults strobe pulses, both arm bits clear, and the state stays PARAM with the lock flag kept. Writing that register with bit 0 at 0 loads bit 1 into the restore arm and bit 2 into the recover arm.
- R10: If the output supply is lost in NORMAL, NOTRDY or FAULT while restore is not armed, the sequencer soft-resets, clears user-OK and moves to PARAM.
- R11: If the output supply is lost in those states while restore is armed, the sequencer moves to XFER with the transfer direction toward the output side (xferFromOut low). When that transfer completes it enters NORMAL and sets restoreDone, which then stays set.
- R12: Whenever the input supply is not good, the next state is OFF. If recover is armed, and lock and user-OK are set and the output supply is good, then the supply's return goes straight to XFER with xferFromOut high. Completion of that transfer sets recoverDone, which then stays set. Otherwise the ordinary exit of R2 applies.
- R13: The ready pull-down is on in every state except NORMAL and FAULT. PWM enable is high only in NORMAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| vccInGood | input | 1 | Input-side supply good |
| vccOutGood | input | 1 | Output-side supply good |
| pwmIn | input | 1 | PWM input level |
| rdyLine | input | 1 | Sensed level of the shared ready line |
| fltLine | input | 1 | Sensed level of the shared fault line (low = fault) |
| secFault | input | 1 | Output side reports a fault |
| secRdyAck | input | 1 | Output side acknowledges transfer complete |
| clearDone | input | 1 | Fault-clear flow completed |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register write address |
| regWdata | input | 3 | Low control bits of the write data |
| regAccept | output | 1 | Write permitted in the current state |
| opState | output | 3 | Current state code |
| pwmEnable | output | 1 | PWM passed to the power stage |
| rdyPullLow | output | 1 | Drive the ready line low |
| permAddr | output | 1 | Address registers writable |
| permLock | output | 1 | Lock register writable |
| permCfg | output | 1 | Configuration registers writable |
| permUserOk | output | 1 | User-OK register writable |
| xferReq | output | 1 | Parameter transfer in progress |
| xferFromOut | output | 1 | Transfer reloads from the output side |
| cfgDefaults | output | 1 | One-cycle strobe returning configuration to defaults |
| addrLocked | output | 1 | Address lock flag |
| userOk | output | 1 | User-OK flag |
| restoreArmed | output | 1 | Restore arm bit |
| recoverArmed | output | 1 | Recover arm bit |
| restoreDone | output | 1 | Sticky restore success |
| recoverDone | output | 1 | Sticky recover success |

## Verification
Each state change and flag update is due one clock edge after the inputs that cause it. cfgDefaults is high for exactly the one cycle after that edge. regAccept and the permission outputs depend combinationally on the present state and the write inputs. The bench therefore drives the inputs one time unit after a rising edge and reads regAccept in that same cycle. It reads states, flags and the strobe one time unit after the following rising edge. Where a transition should not happen, the bench holds the stimulus for extra edges and checks that the state is unchanged.

// File: rtl/opseq_pkg.sv
package opseq_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_ADDR   = 3'd1,
    ST_PARAM  = 3'd2,
    ST_XFER   = 3'd3,
    ST_NORMAL = 3'd4,
    ST_NOTRDY = 3'd5,
    ST_FAULT  = 3'd6
  } opState_t;

  typedef enum logic [1:0] {
    XK_NONE    = 2'd0,
    XK_RESTORE = 2'd1,
    XK_RECOVER = 2'd2
  } xferKind_t;

  typedef enum logic [2:0] {
    AC_DEV, AC_LOCK, AC_USEROK, AC_SAFE, AC_CFG, AC_RO
  } addrClass_t;

  // strobes from control to the flag datapath
  typedef struct packed {
    logic       setLock;
    logic       clrLock;
    logic       setUserOk;
    logic       clrUserOk;
    logic       softRst;
    logic       loadSafe;
    logic [1:0] safeVal;
    logic       armRestore;
    logic       armRecover;
    logic       xferDone;
  } seqStb_t;
endpackage

// File: rtl/opseq_ctrl.sv
module opseq_ctrl
  import opseq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WD_W = 3,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] GRP_ADDR = 'h01,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 'h02,
  parameter logic [ADDR_W-1:0] USEROK_ADDR = 'h1C,
  parameter logic [ADDR_W-1:0] SAFE_ADDR = 'h1D,
  parameter logic [ADDR_W-1:0] CFG_FIRST = 'h03,
  parameter logic [ADDR_W-1:0] CFG_LAST = 'h25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vccInGood,
  input  logic              vccOutGood,
  input  logic              pwmIn,
  input  logic              rdyLine,
  input  logic              fltLine,
  input  logic              secFault,
  input  logic              secRdyAck,
  input  logic              clearDone,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WD_W-1:0]   regWdata,
  input  logic              lockBit,
  input  logic              userOkBit,
  input  logic              restoreEn,
  input  logic              recoverEn,
  output opState_t          state,
  output seqStb_t           stb,
  output logic              accept
);
  opState_t stNext;
  addrClass_t cls;

  function automatic addrClass_t classify(input logic [ADDR_W-1:0] a);
    if (a == DEV_ADDR || a == GRP_ADDR) return AC_DEV;
    if (a == LOCK_ADDR) return AC_LOCK;
    if (a == USEROK_ADDR) return AC_USEROK;
    if (a == SAFE_ADDR) return AC_SAFE;
    if (a >= CFG_FIRST && a <= CFG_LAST) return AC_CFG;
    return AC_RO;
  endfunction

  assign cls = classify(regAddr);

  always_comb begin
    unique case (state)
      ST_ADDR:   accept = regWr && (cls == AC_DEV || cls == AC_LOCK);
      ST_PARAM:  accept = regWr && (cls == AC_LOCK || cls == AC_CFG ||
                                    cls == AC_USEROK || cls == AC_SAFE);
      ST_NOTRDY: accept = regWr && (cls == AC_USEROK);
      default:   accept = 1'b0;
    endcase
  end

  always_comb begin
    stNext = state;
    stb = '0;
    stb.safeVal = regWdata[2:1];
    if (!vccInGood) begin
      stNext = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF: begin
          if (recoverEn && lockBit && userOkBit && vccOutGood) begin
            stNext = ST_XFER;
            stb.armRecover = 1'b1;
          end else if (pwmIn) begin
            stNext = ST_ADDR;
            stb.softRst = 1'b1;
            stb.clrLock = 1'b1;
            stb.clrUserOk = 1'b1;
          end
        end
        ST_ADDR: begin
          if (accept && cls == AC_LOCK && regWdata[0]) begin
            stb.setLock = 1'b1;
            stNext = ST_PARAM;
          end
        end
        ST_PARAM: begin
          if (accept) begin
            if (cls == AC_LOCK && !regWdata[0]) begin
              stb.clrLock = 1'b1;
              stNext = ST_ADDR;
            end else if (cls == AC_USEROK && regWdata[0]) begin
              stb.setUserOk = 1'b1;
              stNext = ST_XFER;
            end else if (cls == AC_SAFE) begin
              if (regWdata[0]) stb.softRst = 1'b1;
              else stb.loadSafe = 1'b1;
            end
          end
        end
        ST_XFER: begin
          if (vccOutGood && secRdyAck) begin
            stNext = ST_NORMAL;
            stb.xferDone = 1'b1;
          end
        end
        ST_NORMAL, ST_NOTRDY, ST_FAULT: begin
          if (!vccOutGood) begin
            if (restoreEn) begin
              stNext = ST_XFER;
              stb.armRestore = 1'b1;
            end else begin
              stNext = ST_PARAM;
              stb.softRst = 1'b1;
              stb.clrUserOk = 1'b1;
            end
          end else if (state == ST_NORMAL) begin
            if (!fltLine || secFault) stNext = ST_FAULT;
            else if (!rdyLine) stNext = ST_NOTRDY;
          end else if (state == ST_NOTRDY) begin
            if (accept && cls == AC_USEROK && !regWdata[0]) begin
              stb.clrUserOk = 1'b1;
              stNext = ST_PARAM;
            end else if (rdyLine) begin
              stNext = ST_NORMAL;
            end
          end else if (clearDone) begin
            stNext = ST_NORMAL;
          end
        end
        default: stNext = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else state <= stNext;
  end
endmodule

// File: rtl/opseq_flags.sv
module opseq_flags
  import opseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  seqStb_t stb,
  output logic    lockBit,
  output logic    userOkBit,
  output logic    restoreEn,
  output logic    recoverEn,
  output logic    restoreOk,
  output logic    recoverOk,
  output logic    fromOut,
  output logic    defaultsPulse
);
  xferKind_t kind;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockBit <= 1'b0;
      userOkBit <= 1'b0;
      restoreEn <= 1'b0;
      recoverEn <= 1'b0;
      restoreOk <= 1'b0;
      recoverOk <= 1'b0;
      kind <= XK_NONE;
      defaultsPulse <= 1'b0;
    end else begin
      defaultsPulse <= stb.softRst;
      if (stb.setLock) lockBit <= 1'b1;
      else if (stb.clrLock) lockBit <= 1'b0;
      if (stb.setUserOk) userOkBit <= 1'b1;
      else if (stb.clrUserOk) userOkBit <= 1'b0;
      if (stb.softRst) begin
        restoreEn <= 1'b0;
        recoverEn <= 1'b0;
      end else if (stb.loadSafe) begin
        restoreEn <= stb.safeVal[0];
        recoverEn <= stb.safeVal[1];
      end
      if (stb.armRestore) kind <= XK_RESTORE;
      else if (stb.armRecover) kind <= XK_RECOVER;
      else if (stb.xferDone) begin
        if (kind == XK_RESTORE) restoreOk <= 1'b1;
        if (kind == XK_RECOVER) recoverOk <= 1'b1;
        kind <= XK_NONE;
      end
    end
  end

  assign fromOut = (kind == XK_RECOVER);
endmodule

// File: rtl/drv_opstate_seq.sv
module drv_opstate_seq
  import opseq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WD_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vccInGood,
  input  logic              vccOutGood,
  input  logic              pwmIn,
  input  logic              rdyLine,
  input  logic              fltLine,
  input  logic              secFault,
  input  logic              secRdyAck,
  input  logic              clearDone,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WD_W-1:0]   regWdata,
  output logic              regAccept,
  output logic [2:0]        opState,
  output logic              pwmEnable,
  output logic              rdyPullLow,
  output logic              permAddr,
  output logic              permLock,
  output logic              permCfg,
  output logic              permUserOk,
  output logic              xferReq,
  output logic              xferFromOut,
  output logic              cfgDefaults,
  output logic              addrLocked,
  output logic              userOk,
  output logic              restoreArmed,
  output logic              recoverArmed,
  output logic              restoreDone,
  output logic              recoverDone
);
  opState_t state;
  seqStb_t stb;

  opseq_ctrl #(.ADDR_W(ADDR_W), .WD_W(WD_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .vccInGood(vccInGood), .vccOutGood(vccOutGood),
    .pwmIn(pwmIn), .rdyLine(rdyLine), .fltLine(fltLine), .secFault(secFault),
    .secRdyAck(secRdyAck), .clearDone(clearDone), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .lockBit(addrLocked),
    .userOkBit(userOk), .restoreEn(restoreArmed), .recoverEn(recoverArmed),
    .state(state), .stb(stb), .accept(regAccept)
  );

  opseq_flags i_flags (
    .clk(clk), .rstN(rstN), .stb(stb), .lockBit(addrLocked),
    .userOkBit(userOk), .restoreEn(restoreArmed), .recoverEn(recoverArmed),
    .restoreOk(restoreDone), .recoverOk(recoverDone), .fromOut(xferFromOut),
    .defaultsPulse(cfgDefaults)
  );

  assign opState = state;
  assign pwmEnable = (state == ST_NORMAL);
  assign rdyPullLow = !(state == ST_NORMAL || state == ST_FAULT);
  assign xferReq = (state == ST_XFER);
  assign permAddr = (state == ST_ADDR);
  assign permLock = (state == ST_ADDR) || (state == ST_PARAM);
  assign permCfg = (state == ST_PARAM);
  assign permUserOk = (state == ST_PARAM) || (state == ST_NOTRDY);
endmodule

// File: rtl/opseq_chk.sv
module opseq_chk
  import opseq_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       vccInGood,
  input logic       vccOutGood,
  input logic       fltLine,
  input logic       secFault,
  input logic       secRdyAck,
  input logic [2:0] opState,
  input logic       pwmEnable,
  input logic       regAccept,
  input logic       restoreDone,
  input logic       recoverDone,
  input logic       cfgDefaults,
  input logic       addrLocked
);
  AST_OFF_NO_SUPPLY: assert property (@(posedge clk) disable iff (!rstN)
    !vccInGood |=> opState == ST_OFF); // R12
  AST_XFER_WAITS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (opState == ST_XFER && vccInGood && !(vccOutGood && secRdyAck)) |=> opState == ST_XFER); // R5
  AST_RUN_ENTRY_PATH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmEnable) |-> ($past(opState) == ST_XFER || $past(opState) == ST_NOTRDY ||
                          $past(opState) == ST_FAULT)); // R13
  AST_FAULT_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (opState == ST_NORMAL && vccInGood && vccOutGood && (!fltLine || secFault))
      |=> opState == ST_FAULT); // R7
  AST_NO_WRITE_LOCKED_STATES: assert property (@(posedge clk) disable iff (!rstN)
    (opState == ST_OFF || opState == ST_XFER || opState == ST_NORMAL || opState == ST_FAULT)
      |-> !regAccept); // R8
  AST_RESTORE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    restoreDone |=> restoreDone); // R11
  AST_RECOVER_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    recoverDone |=> recoverDone); // R12
  AST_SOFTRST_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDefaults && opState == ST_PARAM && $past(opState) == ST_PARAM) |-> addrLocked); // R9
endmodule

bind drv_opstate_seq opseq_chk i_chk (.*);

// File: tb/test_drv_opstate_seq.sv
module test_drv_opstate_seq;
  localparam int PERIOD = 10;
  localparam int NV = 22;

  logic clk = 1'b0;
  logic rstN;
  logic vccInGood, vccOutGood, pwmIn, rdyLine, fltLine, secFault, secRdyAck, clearDone;
  logic regWr;
  logic [7:0] regAddr;
  logic [2:0] regWdata;
  logic regAccept, pwmEnable, rdyPullLow, permAddr, permLock, permCfg, permUserOk;
  logic xferReq, xferFromOut, cfgDefaults, addrLocked, userOk;
  logic restoreArmed, recoverArmed, restoreDone, recoverDone;
  logic [2:0] opState;
  logic [2:0] expS;
  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  drv_opstate_seq i_drv_opstate_seq (.*);

  // vector: vin vout pwm rdy flt secF ack clr wr | addr | data | state
  localparam logic [22:0] VEC [NV] = '{
    {9'b000110000, 8'h00, 3'd0, 3'd0},
    {9'b100110000, 8'h00, 3'd0, 3'd0},
    {9'b101110000, 8'h00, 3'd0, 3'd1},
    {9'b100110001, 8'h02, 3'd0, 3'd1},
    {9'b100110001, 8'h02, 3'd1, 3'd2},
    {9'b100110001, 8'h02, 3'd0, 3'd1},
    {9'b100110001, 8'h02, 3'd1, 3'd2},
    {9'b100110001, 8'h1C, 3'd1, 3'd3},
    {9'b100110100, 8'h00, 3'd0, 3'd3},
    {9'b110110000, 8'h00, 3'd0, 3'd3},
    {9'b110110100, 8'h00, 3'd0, 3'd4},
    {9'b110010000, 8'h00, 3'd0, 3'd5},
    {9'b110110000, 8'h00, 3'd0, 3'd4},
    {9'b110100000, 8'h00, 3'd0, 3'd6},
    {9'b110110000, 8'h00, 3'd0, 3'd6},
    {9'b110110010, 8'h00, 3'd0, 3'd4},
    {9'b110011000, 8'h00, 3'd0, 3'd6},
    {9'b110110010, 8'h00, 3'd0, 3'd4},
    {9'b110010000, 8'h00, 3'd0, 3'd5},
    {9'b110010001, 8'h1C, 3'd0, 3'd2},
    {9'b110110001, 8'h1C, 3'd1, 3'd3},
    {9'b110110100, 8'h00, 3'd0, 3'd4}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] d, input int expAcc, input string req);
    regWr = 1'b1;
    regAddr = a;
    regWdata = d;
    #1;
    chk(req, regAccept, expAcc);
    step();
    regWr = 1'b0;
  endtask

  // R4 R13: outputs expected for each state code
  task automatic chkStateOut(input int s);
    chk("R13 pwmEnable", pwmEnable, (s == 4));
    chk("R13 rdyPullLow", rdyPullLow, !(s == 4 || s == 6));
    chk("R4 permAddr", permAddr, (s == 1));
    chk("R4 permLock", permLock, (s == 1 || s == 2));
    chk("R4 permCfg", permCfg, (s == 2));
    chk("R4 permUserOk", permUserOk, (s == 2 || s == 5));
  endtask

  initial begin
    rstN = 1'b0;
    {vccInGood, vccOutGood, pwmIn, secFault, secRdyAck, clearDone, regWr} = '0;
    rdyLine = 1'b1;
    fltLine = 1'b1;
    regAddr = '0;
    regWdata = '0;
    expS = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 state", opState, 0);
    chkStateOut(0);
    chk("R1 lock", addrLocked, 0);
    chk("R1 userOk", userOk, 0);
    chk("R1 restoreDone", restoreDone, 0);
    chk("R1 recoverDone", recoverDone, 0);
    chk("R1 arms", {restoreArmed, recoverArmed}, 0);
    rstN = 1'b1;

    // R2 R3 R5 R6 R7 main walk
    for (int i = 0; i < NV; i++) begin
      {vccInGood, vccOutGood, pwmIn, rdyLine, fltLine, secFault, secRdyAck, clearDone,
       regWr, regAddr, regWdata, expS} = VEC[i];
      step();
      chk($sformatf("R5 R6 R7 R3 R2 vector %0d state", i), opState, expS);
      chkStateOut(expS);
    end
    regWr = 1'b0;
    secRdyAck = 1'b0;
    clearDone = 1'b0;

    // R8 lock write refused in NORMAL
    wr(8'h02, 3'd0, 0, "R8 accept in NORMAL");
    chk("R8 state", opState, 4);
    chk("R8 lock kept", addrLocked, 1);

    // R10 output supply lost, restore not armed
    vccOutGood = 1'b0;
    step();
    chk("R10 state", opState, 2);
    chk("R10 userOk", userOk, 0);
    chk("R10 defaults", cfgDefaults, 1);
    vccOutGood = 1'b1;
    step();
    chk("R10 defaults one cycle", cfgDefaults, 0);

    // R9 arm and soft reset
    wr(8'h1D, 3'b110, 1, "R9 safe accept");
    chk("R9 armed", {restoreArmed, recoverArmed}, 3);
    wr(8'h1D, 3'b001, 1, "R9 softreset accept");
    chk("R9 defaults", cfgDefaults, 1);
    chk("R9 arms cleared", {restoreArmed, recoverArmed}, 0);
    chk("R9 lock kept", addrLocked, 1);
    chk("R9 state", opState, 2);

    // R11 restore
    wr(8'h1D, 3'b010, 1, "R11 arm accept");
    wr(8'h1C, 3'b001, 1, "R11 userOk accept");
    secRdyAck = 1'b1;
    step();
    secRdyAck = 1'b0;
    chk("R11 running", opState, 4);
    vccOutGood = 1'b0;
    step();
    chk("R11 xfer", opState, 3);
    chk("R11 direction", xferFromOut, 0);
    step();
    chk("R11 waits", opState, 3);
    chk("R11 not done yet", restoreDone, 0);
    vccOutGood = 1'b1;
    secRdyAck = 1'b1;
    step();
    secRdyAck = 1'b0;
    chk("R11 back to normal", opState, 4);
    chk("R11 restoreDone", restoreDone, 1);
    chk("R11 userOk kept", userOk, 1);

    // R12 recover
    rdyLine = 1'b0;
    step();
    chk("R6 notready", opState, 5);
    wr(8'h1C, 3'b000, 1, "R6 userOk clear accept");
    rdyLine = 1'b1;
    chk("R6 to param", opState, 2);
    wr(8'h1D, 3'b100, 1, "R12 arm accept");
    chk("R12 armed", {restoreArmed, recoverArmed}, 1);
    wr(8'h1C, 3'b001, 1, "R12 userOk accept");
    secRdyAck = 1'b1;
    step();
    secRdyAck = 1'b0;
    chk("R12 running", opState, 4);
    vccInGood = 1'b0;
    step();
    chk("R12 off", opState, 0);
    step();
    vccInGood = 1'b1;
    step();
    chk("R12 reload xfer", opState, 3);
    chk("R12 direction", xferFromOut, 1);
    secRdyAck = 1'b1;
    step();
    secRdyAck = 1'b0;
    chk("R12 normal", opState, 4);
    chk("R12 recoverDone", recoverDone, 1);

    // R12 R2 plain exit when output side also lost
    vccInGood = 1'b0;
    vccOutGood = 1'b0;
    step();
    chk("R12 off again", opState, 0);
    vccInGood = 1'b1;
    pwmIn = 1'b1;
    step();
    pwmIn = 1'b0;
    chk("R2 addr", opState, 1);
    chk("R2 lock cleared", addrLocked, 0);
    chk("R2 userOk cleared", userOk, 0);
    chk("R2 defaults", cfgDefaults, 1);
    chk("R2 recover disarmed", recoverArmed, 0);
    chk("R11 restoreDone sticky", restoreDone, 1);
    regWr = 1'b1;
    regAddr = 8'h00;
    #1;
    chk("R4 device addr accept in ADDR", regAccept, 1);
    regAddr = 8'h10;
    #1;
    chk("R8 cfg refused in ADDR", regAccept, 0);
    step();
    regWr = 1'b0;
    chk("R8 state kept", opState, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule